// File: doc/BRIEF.md
# Two-Class Interrupt Priority Resolver

This block sits between the interrupt source logic of a processor subsystem and the core's two interrupt inputs, the normal request and the fast request. Source lines come in up to three banks of 32 each. For every line the block receives four things: a pending bit, a mask bit, a class steering bit and a small priority number. From these it selects one winning line for each class, and it drives one request output for each class.

A request is not driven again simply because something is pending. Each class keeps an armed flag. The flag is set at reset and again each time software acknowledges that class with a new-agreement pulse. A request rises only when the class is armed, some line of that class is eligible, and the global enable is on. On that clock edge the winning line's number is captured as the class code and the flag clears. The request and the code then stay unchanged until the next acknowledge. The acknowledge pulse drops the request. One cycle later the block resolves the class again against the inputs as they are then.

Top module: `dual_class_arbiter`

## Requirements
- R1: A line is eligible for a class when it is pending, its mask bit is 0, and its steering bit selects the class. Steering bit 1 selects the fast class and steering bit 0 selects the normal class.
- R2: Among eligible lines the one with the smallest priority number wins. Priority 0 is the most urgent.
- R3: When several eligible lines share the smallest priority number, the line with the largest number wins.
- R4: A code is the global line number, 32 × bank + bit position. Bit k of each flat vector is line k, and line k's priority sits in bits [k*6 +: 6] of the priority vector.
- R5: The two classes are resolved and handshaken independently. An acknowledge of one class leaves the other class's request and code unchanged.
- R6: A request rises on a clock edge only if its class is armed, at least one line of the class is eligible and the global enable is 1. On that edge the code takes the winner and the class is disarmed. While disarmed, the code and the request do not follow input changes.
- R7: An acknowledge pulse sampled on an edge forces that class's request low and arms the class. The class is re-resolved on the following edge.
- R8: After reset both requests are 0, both codes are 0 and both classes are armed.
- R9: An armed class with no eligible line keeps its request low and its code unchanged.
- R10: With the global enable at 0 no request rises. A request that is already high stays high until its acknowledge.
- R11: Each class has a combinational hit output that is 1 exactly when at least one line of that class is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| glb_en_i | input | 1 | Global enable for raising requests |
| pend_i | input | 96 | Pending bit per line |
| mask_i | input | 96 | Mask bit per line, 1 masks the line |
| steer_i | input | 96 | Class steering per line, 1 selects the fast class |
| prio_i | input | 576 | Six-bit priority per line, packed by line number |
| ack_irq_i | input | 1 | New-agreement pulse for the normal class |
| ack_fiq_i | input | 1 | New-agreement pulse for the fast class |
| irq_req_o | output | 1 | Normal-class request to the core |
| irq_code_o | output | 7 | Captured normal-class winner line |
| irq_hit_o | output | 1 | Some normal-class line is eligible now |
| fiq_req_o | output | 1 | Fast-class request to the core |
| fiq_code_o | output | 7 | Captured fast-class winner line |
| fiq_hit_o | output | 1 | Some fast-class line is eligible now |

## Verification
The first sweep makes each of the 96 lines the only pending line in turn, with even lines steered to the normal class and odd lines to the fast class. This shows that the code equals the line number in every bank, and that the idle class holds its old code. Patterns where every line is pending with the same priority separate "largest line number wins a tie" from the other tie rules. Patterns with priorities computed by formula, with and without masks, and a long run of pseudo-random vectors compare the winners with an ascending-scan model in the bench. Handshake sequences cover:
- an input change while the class is disarmed;
- the global enable dropped before and after a request rises;
- an acknowledge of one class while the other class is high;
- an acknowledge with nothing pending.

// File: rtl/dca_pkg.sv
package dca_pkg;

  typedef enum logic {
    CLS_IRQ = 1'b0,
    CLS_FIQ = 1'b1
  } cls_e;

  localparam int unsigned CMP_W = 16;

  // Right-hand (higher line numbers) candidate takes the node when it is
  // valid and no less urgent than the left one: ties go to higher lines.
  function automatic logic right_wins(input logic lv, input logic rv,
                                      input logic [CMP_W-1:0] lp,
                                      input logic [CMP_W-1:0] rp);
    return rv && (!lv || (rp <= lp));
  endfunction

  function automatic int unsigned global_line(input int unsigned bank,
                                              input int unsigned bitpos,
                                              input int unsigned bank_w);
    return bank * bank_w + bitpos;
  endfunction

endpackage

// File: rtl/dca_elig.sv
module dca_elig #(
  parameter int unsigned NBANKS = 3,
  parameter int unsigned BANK_W = 32,
  localparam int unsigned NL    = NBANKS * BANK_W
) (
  input  logic [NL-1:0] pend_i,
  input  logic [NL-1:0] mask_i,
  input  logic [NL-1:0] steer_i,
  output logic [NL-1:0] irq_elig_o,
  output logic [NL-1:0] fiq_elig_o
);
  import dca_pkg::*;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    for (genvar j = 0; j < BANK_W; j++) begin : g_bit
      localparam int unsigned L = global_line(b, j, BANK_W);
      logic live;
      assign live          = pend_i[L] & ~mask_i[L];
      assign irq_elig_o[L] = live & (steer_i[L] == CLS_IRQ);
      assign fiq_elig_o[L] = live & (steer_i[L] == CLS_FIQ);
    end
  end

endmodule

// File: rtl/dca_tree.sv
module dca_tree #(
  parameter int unsigned NL      = 96,
  parameter int unsigned PRIO_W  = 6,
  localparam int unsigned CODE_W = $clog2(NL),
  localparam int unsigned LEAVES = 1 << CODE_W,
  localparam int unsigned NODES  = 2 * LEAVES - 1
) (
  input  logic [NL-1:0]        elig_i,
  input  logic [NL*PRIO_W-1:0] prio_i,
  output logic                 hit_o,
  output logic [CODE_W-1:0]    win_o
);
  import dca_pkg::*;

  // Heap-ordered tree: leaf i at LEAVES-1+i, children of k at 2k+1 / 2k+2,
  // so the left child always covers the lower line numbers.
  logic                nv [NODES];
  logic [PRIO_W-1:0]   np [NODES];
  logic [CODE_W-1:0]   ni [NODES];

  always_comb begin
    for (int i = 0; i < int'(LEAVES); i++) begin
      if (i < int'(NL)) begin
        nv[LEAVES-1+i] = elig_i[i];
        np[LEAVES-1+i] = prio_i[i*PRIO_W +: PRIO_W];
      end else begin
        nv[LEAVES-1+i] = 1'b0;
        np[LEAVES-1+i] = '0;
      end
      ni[LEAVES-1+i] = CODE_W'(i);
    end
    for (int k = int'(LEAVES) - 2; k >= 0; k--) begin
      if (right_wins(nv[2*k+1], nv[2*k+2],
                     CMP_W'(np[2*k+1]), CMP_W'(np[2*k+2]))) begin
        nv[k] = nv[2*k+2];
        np[k] = np[2*k+2];
        ni[k] = ni[2*k+2];
      end else begin
        nv[k] = nv[2*k+1];
        np[k] = np[2*k+1];
        ni[k] = ni[2*k+1];
      end
    end
  end

  assign hit_o = nv[0];
  assign win_o = ni[0];

endmodule

// File: rtl/dca_gate.sv
module dca_gate #(
  parameter int unsigned CODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ack_i,
  input  logic              hit_i,
  input  logic [CODE_W-1:0] win_i,
  output logic              req_o,
  output logic [CODE_W-1:0] code_o
);
  logic              arm_q;
  logic              req_q;
  logic [CODE_W-1:0] code_q;
  logic              fire;

  // Named event: the class delivers on this edge.
  assign fire = arm_q & hit_i & en_i & ~ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b1;
      req_q  <= 1'b0;
      code_q <= '0;
    end else if (ack_i) begin
      arm_q <= 1'b1;
      req_q <= 1'b0;
    end else if (fire) begin
      arm_q  <= 1'b0;
      req_q  <= 1'b1;
      code_q <= win_i;
    end
  end

  assign req_o  = req_q;
  assign code_o = code_q;

  AST_RISE_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(arm_q && hit_i && en_i)); // R6
  AST_RISE_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> !arm_q); // R6
  AST_ACK_DROPS_AND_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (!req_q && arm_q)); // R7
  AST_IDLE_HOLDS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> $stable(code_q)); // R9
  AST_REQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> req_q); // R10
  AST_NO_RISE_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !$rose(req_q)); // R10

endmodule

// File: rtl/dual_class_arbiter.sv
module dual_class_arbiter #(
  parameter int unsigned NBANKS  = 3,
  parameter int unsigned BANK_W  = 32,
  parameter int unsigned PRIO_W  = 6,
  localparam int unsigned NL     = NBANKS * BANK_W,
  localparam int unsigned CODE_W = $clog2(NL)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 glb_en_i,
  input  logic [NL-1:0]        pend_i,
  input  logic [NL-1:0]        mask_i,
  input  logic [NL-1:0]        steer_i,
  input  logic [NL*PRIO_W-1:0] prio_i,
  input  logic                 ack_irq_i,
  input  logic                 ack_fiq_i,
  output logic                 irq_req_o,
  output logic [CODE_W-1:0]    irq_code_o,
  output logic                 irq_hit_o,
  output logic                 fiq_req_o,
  output logic [CODE_W-1:0]    fiq_code_o,
  output logic                 fiq_hit_o
);
  import dca_pkg::*;

  localparam int unsigned NCLS = 2;
  localparam int unsigned IX_I = int'(CLS_IRQ);
  localparam int unsigned IX_F = int'(CLS_FIQ);

  logic [NL-1:0]     elig_c [NCLS];
  logic              ack_c  [NCLS];
  logic              hit_c  [NCLS];
  logic [CODE_W-1:0] win_c  [NCLS];
  logic              req_c  [NCLS];
  logic [CODE_W-1:0] code_c [NCLS];

  dca_elig #(.NBANKS(NBANKS), .BANK_W(BANK_W)) u_elig (
    .pend_i     (pend_i),
    .mask_i     (mask_i),
    .steer_i    (steer_i),
    .irq_elig_o (elig_c[IX_I]),
    .fiq_elig_o (elig_c[IX_F])
  );

  assign ack_c[IX_I] = ack_irq_i;
  assign ack_c[IX_F] = ack_fiq_i;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    dca_tree #(.NL(NL), .PRIO_W(PRIO_W)) u_tree (
      .elig_i (elig_c[c]),
      .prio_i (prio_i),
      .hit_o  (hit_c[c]),
      .win_o  (win_c[c])
    );

    dca_gate #(.CODE_W(CODE_W)) u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (glb_en_i),
      .ack_i  (ack_c[c]),
      .hit_i  (hit_c[c]),
      .win_i  (win_c[c]),
      .req_o  (req_c[c]),
      .code_o (code_c[c])
    );

    AST_WIN_IS_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_c[c] |-> elig_c[c][win_c[c]]); // R1
    AST_HIT_MATCHES_ELIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_c[c] == (|elig_c[c])); // R11
  end

  AST_CLASSES_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig_c[IX_I] & elig_c[IX_F]) == '0); // R5

  assign irq_req_o  = req_c[IX_I];
  assign irq_code_o = code_c[IX_I];
  assign irq_hit_o  = hit_c[IX_I];
  assign fiq_req_o  = req_c[IX_F];
  assign fiq_code_o = code_c[IX_F];
  assign fiq_hit_o  = hit_c[IX_F];

endmodule

// File: tb/test_dual_class_arbiter.sv
`timescale 1ns/1ps
module test_dual_class_arbiter;
  localparam int NL = 96;
  localparam int PW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [NL-1:0] pend = '0, msk = '0, steer = '0;
  int prio [NL];
  logic [NL*PW-1:0] prio_flat;
  logic ack_i = 1'b0, ack_f = 1'b0;
  logic irq_req, fiq_req, irq_hit, fiq_hit;
  logic [6:0] irq_code, fiq_code;

  int n_chk = 0, n_fail = 0;
  int last_code [2];
  int lfsr = 32'h1ace_b00c;

  always #5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NL; k++) prio_flat[k*PW +: PW] = PW'(prio[k]);
  end

  dual_class_arbiter i_dual_class_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(en),
    .pend_i(pend), .mask_i(msk), .steer_i(steer), .prio_i(prio_flat),
    .ack_irq_i(ack_i), .ack_fiq_i(ack_f),
    .irq_req_o(irq_req), .irq_code_o(irq_code), .irq_hit_o(irq_hit),
    .fiq_req_o(fiq_req), .fiq_code_o(fiq_code), .fiq_hit_o(fiq_hit)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Ascending scan; "<=" lets a later line of equal priority take over.
  function automatic int ref_win(input int cls, output bit any);
    int best = 0, bp = 0;
    any = 0;
    for (int k = 0; k < NL; k++) begin
      if (pend[k] && !msk[k] && (int'(steer[k]) == cls)) begin
        if (!any || prio[k] <= bp) begin
          best = k;
          bp = prio[k];
        end
        any = 1;
      end
    end
    return best;
  endfunction

  function automatic int rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  // Acknowledge both classes, then check the re-resolution one edge later.
  task automatic deliver(input string rq);
    bit ai, af;
    int wi, wf;
    ack_i = 1; ack_f = 1;
    tick();
    ack_i = 0; ack_f = 0;
    chk("R7 irq drop", int'(irq_req), 0);
    chk("R7 fiq drop", int'(fiq_req), 0);
    wi = ref_win(0, ai);
    wf = ref_win(1, af);
    chk("R11 irq hit", int'(irq_hit), int'(ai));
    chk("R11 fiq hit", int'(fiq_hit), int'(af));
    tick();
    if (ai) last_code[0] = wi;
    if (af) last_code[1] = wf;
    chk({rq, " irq req"}, int'(irq_req), int'(ai));
    chk({rq, " irq code"}, int'(irq_code), last_code[0]);
    chk({rq, " fiq req"}, int'(fiq_req), int'(af));
    chk({rq, " fiq code"}, int'(fiq_code), last_code[1]);
  endtask

  initial begin
    #2000000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < NL; k++) prio[k] = 0;
    last_code[0] = 0; last_code[1] = 0;
    #1;
    tick(); tick();
    // R8 reset state
    chk("R8 irq req", int'(irq_req), 0);
    chk("R8 fiq req", int'(fiq_req), 0);
    chk("R8 irq code", int'(irq_code), 0);
    chk("R8 fiq code", int'(fiq_code), 0);
    rst_n = 1;
    tick();

    // R10: armed but disabled
    pend[5] = 1; prio[5] = 9;
    tick(); tick(); tick();
    chk("R10 no rise when disabled", int'(irq_req), 0);
    chk("R11 hit while disabled", int'(irq_hit), 1);
    en = 1;
    tick();
    chk("R6 rise after enable (armed from reset, R8)", int'(irq_req), 1);
    chk("R6 code latched", int'(irq_code), 5);
    chk("R5 fiq untouched", int'(fiq_req), 0);
    last_code[0] = 5;
    // R6: disarmed, new more urgent line does not change code
    pend[9] = 1; prio[9] = 0;
    tick(); tick();
    chk("R6 hold while disarmed", int'(irq_code), 5);
    en = 0;
    tick();
    chk("R10 sticky when disabled", int'(irq_req), 1);
    en = 1;
    pend = '0;

    // R4 single-line sweep across all banks; idle class keeps code (R9)
    for (int l = 0; l < NL; l++) begin
      pend = '0;
      pend[l] = 1;
      steer[l] = l[0];
      prio[l] = (l * 5) % 64;
      deliver("R4 single");
    end

    // R3 ties: all pending, equal priority
    pend = '1; msk = '0;
    for (int k = 0; k < NL; k++) begin steer[k] = k[0]; prio[k] = 17; end
    deliver("R3 tie");
    chk("R3 irq tie winner", int'(irq_code), 94);
    chk("R3 fiq tie winner", int'(fiq_code), 95);

    // R2 formula priorities, then with masks (R1)
    for (int k = 0; k < NL; k++) prio[k] = (k * 37 + 11) % 64;
    deliver("R2 formula");
    for (int k = 0; k < NL; k++) msk[k] = (k % 3 == 0);
    deliver("R1 masked");
    msk = '1;
    deliver("R1 all masked");
    msk = '0;

    // R5: acknowledge only the normal class
    pend = '0; pend[40] = 1; steer[40] = 0; pend[41] = 1; steer[41] = 1;
    deliver("R5 setup");
    pend[40] = 0; pend[60] = 1; steer[60] = 0; pend[63] = 1; steer[63] = 1;
    prio[63] = 0;
    ack_i = 1;
    tick();
    ack_i = 0;
    chk("R5 fiq stays high", int'(fiq_req), 1);
    tick();
    chk("R5 irq new code", int'(irq_code), 60);
    chk("R5 fiq code held", int'(fiq_code), 41);
    chk("R5 fiq req held", int'(fiq_req), 1);
    last_code[0] = 60;

    // R9: nothing pending
    pend = '0;
    deliver("R9 empty");

    // R2/R3 pseudo-random patterns
    for (int it = 0; it < 80; it++) begin
      for (int w = 0; w < NL / 32; w++) begin
        pend[w*32 +: 32] = rnd();
        msk[w*32 +: 32] = rnd() & rnd();
        steer[w*32 +: 32] = rnd();
      end
      for (int k = 0; k < NL; k++) prio[k] = (it < 40) ? (rnd() & 63) : (rnd() & 3);
      deliver("R2 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule